// File: doc/BRIEF.md
# Forward-error-correction codeword transmit assembler

This block turns a stream of 66-bit coded blocks into fixed-length FEC codewords sent as a byte stream. It sits below the 64b/66b coding sublayer, in front of the medium attachment. Each codeword starts with a constant synchronization field. The payload follows, made of 28 input blocks laid end to end with their 2-bit sync headers kept. Reed-Solomon parity computed over that payload closes the codeword. The result is 252 bytes per codeword, so the line carries 9/8 of the 64-bit data rate.

Blocks arrive on a valid/ready handshake. The assembler lowers ready while it sends synchronization or parity bytes, which stalls the source, so no block is lost. The parity comes from a Reed-Solomon code over GF(2^8), shortened to 247 symbols: 231 payload bytes followed by 16 check bytes. The synchronization bytes take no part in the parity. The output is a byte with a valid strobe and a flag that marks the first byte of every codeword.

Top module: `fecTxAssembler`

## Requirements
- R1: `outStart` is high only with `outValid`, and only on the first byte of each codeword. The first byte sent after reset carries `outStart`.
- R2: Each codeword begins with 5 bytes taken from the 40-bit `SYNC_PATTERN`, most significant byte first. The default pattern is 40'hC35AE1960F.
- R3: The next 231 bytes hold the bits of 28 accepted blocks, concatenated with no padding. Block bit 65 comes first within each block. Payload byte bit 7 holds the earliest bit.
- R4: The last 16 bytes are RS parity over GF(2^8) with field polynomial 0x11D and alpha = 0x02. Take the 231 payload bytes (the first has the highest degree) followed by the 16 parity bytes (the first sent has the higher degree). That 247-symbol polynomial is zero at alpha^0 through alpha^15.
- R5: Every codeword is exactly 252 valid bytes long, and consecutive `outStart` flags are 252 valid bytes apart.
- R6: No block is accepted while synchronization or parity bytes are being produced. In byte-position terms: no handshake happens between the emission of the last payload byte and the emission of the fourth synchronization byte of the next codeword.
- R7: Exactly 28 blocks are accepted per codeword, and every handshake delivers one block into the payload. A block held valid through a stall is taken exactly once.
- R8: When the source stops, the block emits only whole bytes it already holds, then holds `outValid` low. With 5 blocks fed into a fresh codeword, 46 bytes come out: 5 sync bytes and 41 payload bytes.
- R9: Parity state is cleared at the start of every codeword, so an all-zero payload yields 16 zero parity bytes even right after a non-zero codeword.
- R10: While reset (`rstN` low) is applied, `outValid` and `inReady` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inBlock | input | BLOCK_W (66) | 66-bit coded block, header in the top two bits |
| inValid | input | 1 | Source offers a block |
| inReady | output | 1 | Assembler takes the block on this clock edge if valid |
| outData | output | 8 | Codeword byte |
| outValid | output | 1 | `outData` holds a byte this cycle |
| outStart | output | 1 | Marks the first synchronization byte of a codeword |

## Verification
The control decides what to emit in a given cycle, and the byte appears on `outData` one clock edge later. A block taken at an edge therefore has its first payload byte visible one cycle after the next emission decision, and parity byte k appears k+1 edges after the last payload byte has been folded in. The bench samples every output and `inReady` on the falling edge, stores valid bytes in arrival order, and checks codewords by byte position rather than absolute cycle. It uses cycle counts only for the stall case, where it waits well past the 9 cycles that the buffered bytes need to drain. Handshakes are tied to the byte position last seen on the output, which is how the stall windows of R6 are checked.

// File: rtl/fecTxPkg.sv
package fecTxPkg;

  localparam int BLOCK_W_DEF  = 66;
  localparam int BLOCKS_DEF   = 28;
  localparam int SYNC_BYTES_DEF = 5;
  localparam int PARITY_BYTES_DEF = 16;
  localparam logic [7:0] FIELD_POLY_LOW = 8'h1D;  // x^8+x^4+x^3+x^2+1

  typedef struct packed {
    logic       emitSync;
    logic       emitPay;
    logic       emitPar;
    logic       loadBlk;
    logic       clrPar;
    logic       startMark;
    logic [2:0] fillBits;
    logic [7:0] phaseIdx;
  } fecStrobe_t;

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] aa;
    acc = 8'h00;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = {aa[6:0], 1'b0} ^ (aa[7] ? FIELD_POLY_LOW : 8'h00);
    end
    return acc;
  endfunction

endpackage

// File: rtl/fecTxCtrl.sv
module fecTxCtrl
  import fecTxPkg::*;
#(
  parameter int BLOCK_W      = BLOCK_W_DEF,
  parameter int BLOCKS       = BLOCKS_DEF,
  parameter int SYNC_BYTES   = SYNC_BYTES_DEF,
  parameter int PARITY_BYTES = PARITY_BYTES_DEF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  output fecStrobe_t stb
);

  localparam int PAY_BYTES = BLOCKS * BLOCK_W / 8;
  localparam int CNT_W     = $clog2(PAY_BYTES + 1);
  localparam int BIT_W     = $clog2(BLOCK_W + 8);
  localparam int BLK_W     = $clog2(BLOCKS + 1);

  typedef enum logic [1:0] {ST_SYNC, ST_PAY, ST_PAR} phase_t;

  phase_t           state, nextState;
  logic [CNT_W-1:0] idx;
  logic [BIT_W-1:0] bitCnt;
  logic [BLK_W-1:0] blkCnt;
  logic             emitAny;

  always_comb begin
    stb       = '0;
    inReady   = 1'b0;
    nextState = state;
    stb.phaseIdx = 8'(idx);
    case (state)
      ST_SYNC: begin
        stb.emitSync  = 1'b1;
        stb.startMark = (idx == '0);
        stb.clrPar    = (idx == '0);
        if (idx == CNT_W'(SYNC_BYTES - 1)) nextState = ST_PAY;
      end
      ST_PAY: begin
        if (bitCnt >= BIT_W'(8)) begin
          stb.emitPay = 1'b1;
          if (idx == CNT_W'(PAY_BYTES - 1)) nextState = ST_PAR;
        end else if (blkCnt < BLK_W'(BLOCKS)) begin
          inReady      = 1'b1;
          stb.loadBlk  = inValid;
          stb.fillBits = bitCnt[2:0];
        end
      end
      default: begin
        stb.emitPar = 1'b1;
        if (idx == CNT_W'(PARITY_BYTES - 1)) nextState = ST_SYNC;
      end
    endcase
  end

  assign emitAny = stb.emitSync | stb.emitPay | stb.emitPar;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_SYNC;
      idx    <= '0;
      bitCnt <= '0;
      blkCnt <= '0;
    end else begin
      state <= nextState;
      if (nextState != state)  idx <= '0;
      else if (emitAny)        idx <= idx + 1'b1;
      if (stb.loadBlk)         bitCnt <= bitCnt + BIT_W'(BLOCK_W);
      else if (stb.emitPay)    bitCnt <= bitCnt - BIT_W'(8);
      if (stb.clrPar)          blkCnt <= '0;
      else if (stb.loadBlk)    blkCnt <= blkCnt + 1'b1;
    end
  end

  // R7: never more blocks in a codeword than it holds
  p_block_limit_r7: assert property (@(posedge clk) disable iff (!rstN)
    blkCnt <= BLK_W'(BLOCKS));

  // R3: payload ends exactly when every block has been drained
  p_payload_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAY && nextState == ST_PAR) |-> (blkCnt == BLK_W'(BLOCKS) && bitCnt == BIT_W'(8)));

  // R6: a block is only loaded during the payload phase
  p_load_phase_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadBlk |-> (state == ST_PAY && !stb.emitSync && !stb.emitPar));

endmodule

// File: rtl/fecTxDatapath.sv
module fecTxDatapath
  import fecTxPkg::*;
#(
  parameter int BLOCK_W      = BLOCK_W_DEF,
  parameter int BLOCKS       = BLOCKS_DEF,
  parameter int SYNC_BYTES   = SYNC_BYTES_DEF,
  parameter int PARITY_BYTES = PARITY_BYTES_DEF,
  parameter logic [SYNC_BYTES*8-1:0] SYNC_PATTERN = 40'hC35AE1960F
) (
  input  logic               clk,
  input  logic               rstN,
  input  fecStrobe_t         stb,
  input  logic [BLOCK_W-1:0] inBlock,
  output logic [7:0]         outData,
  output logic               outValid,
  output logic               outStart
);

  localparam int ACC_W    = BLOCK_W + 8;
  localparam int NPAR     = PARITY_BYTES;
  localparam int CW_BYTES = SYNC_BYTES + BLOCKS * BLOCK_W / 8 + PARITY_BYTES;

  function automatic logic [NPAR:0][7:0] genPoly();
    logic [NPAR:0][7:0] g;
    logic [7:0] root;
    g    = '0;
    g[0] = 8'h01;
    root = 8'h01;
    for (int i = 0; i < NPAR; i++) begin
      for (int j = NPAR; j > 0; j--) g[j] = g[j-1] ^ gfMul(g[j], root);
      g[0] = gfMul(g[0], root);
      root = gfMul(root, 8'h02);
    end
    return g;
  endfunction

  localparam logic [NPAR:0][7:0] GEN = genPoly();

  logic [ACC_W-1:0]     acc;
  logic [NPAR-1:0][7:0] par;
  logic [7:0]           payByte, feedback, syncByte;

  assign payByte  = acc[ACC_W-1 -: 8];
  assign feedback = payByte ^ par[NPAR-1];
  assign syncByte = SYNC_PATTERN[8*(SYNC_BYTES-1-int'(stb.phaseIdx)) +: 8];

  always_ff @(posedge clk) begin
    if (!rstN)            acc <= '0;
    else if (stb.loadBlk) acc <= acc | ({inBlock, 8'h00} >> stb.fillBits);
    else if (stb.emitPay) acc <= acc << 8;
  end

  for (genvar i = 0; i < NPAR; i++) begin : g_stage
    logic [7:0] prevStage;
    if (i == 0) begin : g_first
      assign prevStage = 8'h00;
    end else begin : g_rest
      assign prevStage = par[i-1];
    end
    always_ff @(posedge clk) begin
      if (!rstN || stb.clrPar) par[i] <= 8'h00;
      else if (stb.emitPay)    par[i] <= prevStage ^ gfMul(feedback, GEN[i]);
      else if (stb.emitPar)    par[i] <= prevStage;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData  <= 8'h00;
      outValid <= 1'b0;
      outStart <= 1'b0;
    end else begin
      outValid <= stb.emitSync | stb.emitPay | stb.emitPar;
      outStart <= stb.startMark;
      if (stb.emitSync)     outData <= syncByte;
      else if (stb.emitPay) outData <= payByte;
      else if (stb.emitPar) outData <= par[NPAR-1];
    end
  end

  // checker state: valid bytes seen since the last start flag
  logic [15:0] sinceStart;
  logic        seenStart;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceStart <= '0;
      seenStart  <= 1'b0;
    end else if (outValid) begin
      sinceStart <= outStart ? 16'd1 : sinceStart + 16'd1;
      if (outStart) seenStart <= 1'b1;
    end
  end

  // R1: start flag only accompanies a valid byte
  p_start_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    outStart |-> outValid);

  // R5: start flags are one codeword apart
  p_start_spacing_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outStart && seenStart) |-> (sinceStart == 16'(CW_BYTES)));

endmodule

// File: rtl/fecTxAssembler.sv
module fecTxAssembler
  import fecTxPkg::*;
#(
  parameter int BLOCK_W      = BLOCK_W_DEF,
  parameter int BLOCKS       = BLOCKS_DEF,
  parameter int SYNC_BYTES   = SYNC_BYTES_DEF,
  parameter int PARITY_BYTES = PARITY_BYTES_DEF,
  parameter logic [SYNC_BYTES*8-1:0] SYNC_PATTERN = 40'hC35AE1960F
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [BLOCK_W-1:0] inBlock,
  input  logic               inValid,
  output logic               inReady,
  output logic [7:0]         outData,
  output logic               outValid,
  output logic               outStart
);

  fecStrobe_t stb;

  fecTxCtrl #(
    .BLOCK_W(BLOCK_W), .BLOCKS(BLOCKS),
    .SYNC_BYTES(SYNC_BYTES), .PARITY_BYTES(PARITY_BYTES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .stb(stb)
  );

  fecTxDatapath #(
    .BLOCK_W(BLOCK_W), .BLOCKS(BLOCKS),
    .SYNC_BYTES(SYNC_BYTES), .PARITY_BYTES(PARITY_BYTES),
    .SYNC_PATTERN(SYNC_PATTERN)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .inBlock(inBlock),
    .outData(outData), .outValid(outValid), .outStart(outStart)
  );

  // R10: nothing is offered or accepted while held in reset
  p_reset_quiet_r10: assert property (@(posedge clk)
    (!rstN && !$isunknown(rstN)) |=> (!outValid));

endmodule

// File: tb/tb_fecTxAssembler.sv
`timescale 1ns/1ps
module tb_fecTxAssembler;

  localparam int CW = 252;
  localparam int NBLK = 28;
  localparam int NPAY = 231;
  localparam logic [39:0] SYNC = 40'hC35AE1960F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [65:0] inBlock = '0;
  logic        inValid = 1'b0;
  logic        inReady, outValid, outStart;
  logic [7:0]  outData;

  always #2.5 clk = ~clk;

  fecTxAssembler dut (
    .clk(clk), .rstN(rstN), .inBlock(inBlock), .inValid(inValid),
    .inReady(inReady), .outData(outData), .outValid(outValid), .outStart(outStart)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0]  got[$];
  logic        gotStart[$];
  logic [65:0] sent[$];
  int accepts = 0;
  int badAccepts = 0;
  bit done = 0;

  // monitor, away from the rising edge
  always @(negedge clk) begin
    if (rstN) begin
      int lastPos;
      if (outValid) begin
        got.push_back(outData);
        gotStart.push_back(outStart);
      end
      lastPos = (got.size() == 0) ? CW - 1 : (got.size() - 1) % CW;
      if (inValid && inReady) begin
        accepts++;
        if (lastPos < 4 || lastPos >= NPAY + 4) badAccepts++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      r = {r[6:0], 1'b0} ^ (r[7] ? 8'h1D : 8'h00);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [65:0] mkBlock(input int seed);
    logic [63:0] body = 64'h0123456789ABCDEF ^ (64'(seed) * 64'h9E3779B97F4A7C15);
    return {((seed % 2) == 0) ? 2'b01 : 2'b10, body};
  endfunction

  task automatic sendBlock(input logic [65:0] b, input int gap);
    bit hs;
    inValid = 1'b0;
    repeat (gap) begin @(posedge clk); #1; end
    inValid = 1'b1;
    inBlock = b;
    do begin
      @(negedge clk); hs = inReady;
      @(posedge clk); #1;
    end while (!hs);
    inValid = 1'b0;
    sent.push_back(b);
  endtask

  task automatic waitBytes(input int n);
    while (got.size() < n) begin @(posedge clk); #1; end
  endtask

  task automatic checkCodeword(input int c);
    int base = c * CW;
    int extraStarts = 0;
    int payBad = 0;
    logic [7:0] firstAct = 0, firstExp = 0;
    // R1 / R5: start flag position
    chk(gotStart[base] == 1'b1, "R1", "start flag on first byte", 128'(gotStart[base]), 1);
    for (int i = 1; i < CW; i++) if (gotStart[base + i]) extraStarts++;
    chk(extraStarts == 0, "R5", "start flags inside codeword", 128'(extraStarts), 0);
    // R2: sync bytes
    for (int i = 0; i < 5; i++)
      chk(got[base + i] == SYNC[8*(4-i) +: 8], "R2", "sync byte",
          128'(got[base + i]), 128'(SYNC[8*(4-i) +: 8]));
    // R3: payload packing
    for (int j = 0; j < NPAY; j++) begin
      logic [7:0] e;
      for (int k = 0; k < 8; k++) begin
        int g = j * 8 + k;
        e[7-k] = sent[c*NBLK + g/66][65 - (g % 66)];
      end
      if (got[base + 5 + j] !== e) begin
        if (payBad == 0) begin firstAct = got[base + 5 + j]; firstExp = e; end
        payBad++;
      end
    end
    chk(payBad == 0, "R3", "payload bytes (first mismatch)", 128'(firstAct), 128'(firstExp));
    // R4: syndromes of payload+parity vanish
    begin
      logic [7:0] root = 8'h01;
      int badSyn = 0;
      for (int r = 0; r < 16; r++) begin
        logic [7:0] s = 8'h00;
        for (int n = 0; n < NPAY + 16; n++) s = gm(s, root) ^ got[base + 5 + n];
        if (s != 8'h00) badSyn++;
        root = gm(root, 8'h02);
      end
      chk(badSyn == 0, "R4", "non-zero syndromes", 128'(badSyn), 0);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0; inValid = 1'b0;
    repeat (4) begin @(posedge clk); #1; end
    @(negedge clk);
    chk(outValid == 1'b0, "R10", "outValid in reset", 128'(outValid), 0);
    chk(inReady == 1'b0, "R10", "inReady in reset", 128'(inReady), 0);
    @(posedge clk); #1;
    rstN = 1'b1;
  endtask

  task automatic t_stallThenFill();
    for (int i = 0; i < 5; i++) sendBlock(mkBlock(i), 0);
    repeat (40) begin @(posedge clk); #1; end
    chk(got.size() == 46, "R8", "bytes out after 5 blocks and idle", 128'(got.size()), 46);
    for (int i = 5; i < NBLK; i++) sendBlock(mkBlock(i), i % 3);
    waitBytes(CW);
    checkCodeword(0);
  endtask

  task automatic t_backToBack();
    for (int i = 0; i < NBLK; i++) sendBlock(mkBlock(100 + i), 0);
    waitBytes(2 * CW);
    checkCodeword(1);
  endtask

  task automatic t_zeroPayload();
    int nz = 0;
    for (int i = 0; i < NBLK; i++) sendBlock(66'h0, (i == 7) ? 4 : 0);
    waitBytes(3 * CW);
    checkCodeword(2);
    for (int i = 0; i < 16; i++) if (got[2*CW + 5 + NPAY + i] != 8'h00) nz++;
    chk(nz == 0, "R9", "non-zero parity bytes for zero payload", 128'(nz), 0);
  endtask

  task automatic t_onesPayload();
    for (int i = 0; i < NBLK; i++) sendBlock({66{1'b1}}, 0);
    waitBytes(4 * CW);
    checkCodeword(3);
  endtask

  task automatic finish();
    if (done) return;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", got.size(), 4 * CW);
    finish();
  end

  initial begin
    t_reset();
    t_stallThenFill();
    t_backToBack();
    t_zeroPayload();
    t_onesPayload();
    repeat (20) begin @(posedge clk); #1; end
    chk(badAccepts == 0, "R6", "handshakes during sync/parity", 128'(badAccepts), 0);
    chk(accepts == sent.size(), "R7", "handshake count", 128'(accepts), 128'(sent.size()));
    chk(accepts == 4 * NBLK, "R7", "blocks per four codewords", 128'(accepts), 128'(4 * NBLK));
    finish();
  end

endmodule